// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block sits between a synchronous host and an asynchronous 16-bit static RAM of 256K words. The host issues one request at a time with a request/ready handshake: a word address, a read or write flag, write data and one enable bit per byte. The controller turns each request into a registered strobe sequence on the memory pins. The pins are a low-active and a high-active chip select, one low-active control per byte, low-active write and output enables, and a data bus split into out, out-enable and in for an external tristate pad.

All access windows are counted in clock cycles. Each count comes from a nanosecond minimum of the memory, divided by the clock period parameter `CLK_NS` and rounded up. At the default of 10 ns this gives a 6-cycle write strobe inside a 7-cycle write access, a 7-cycle read window, and 3 turnaround cycles after a read. Between accesses the memory is deselected and the bus is released. Read data is captured at the end of the read window and returned with a one-cycle valid pulse.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, and whenever no access is in progress, the outputs are `sram_cs1_n_o`=1, `sram_cs2_o`=0, `sram_bc_n_o`=2'b11, `sram_we_n_o`=1, `sram_oe_n_o`=1, `sram_dq_oe_o`=0 and `ready_o`=1.
- R2: Host `be_i[0]` drives `sram_bc_n_o[0]` low and selects the low byte (data bits 7:0). `be_i[1]` drives `sram_bc_n_o[1]` low and selects the high byte (bits 15:8). A write changes only the enabled bytes. A read reports the enabled bytes.
- R3: A write with at least one byte enabled starts on the cycle after acceptance. It selects the chip and byte controls for 7 cycles. `sram_we_n_o` is low for the first 6 of those cycles and rises one cycle before deselect. `sram_dq_oe_o` is high for the whole access. The write enable is never low unless the chip and a byte control are selected.
- R4: Address, byte controls and write data on the memory pins do not change while the chip is selected.
- R5: A read with at least one byte enabled selects the chip with `sram_oe_n_o` low and `sram_we_n_o` high for 7 cycles. The value on `sram_dq_i` in the last of those cycles appears on `rdata_o`, with `rvalid_o` high for exactly the one cycle after the window closes.
- R6: After a read, the controller keeps the memory deselected and `ready_o` low for 3 cycles before the next request can be accepted. `sram_dq_oe_o` is never high while `sram_oe_n_o` is low.
- R7: `ready_o` is low from the cycle after acceptance until the sequence and any turnaround end: 7 cycles for a write, 10 for a read. A request held while `ready_o` is low has no effect.
- R8: A request with `be_i`=0 drives no strobe and leaves `ready_o` high. As a write it changes no memory word. As a read it returns `rdata_o`=0 with `rvalid_o` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, taken on a clock edge where ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| ready_o | output | 1 | Controller can accept a request |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | One-cycle pulse marking rdata_o |
| sram_addr_o | output | 18 | Memory address |
| sram_cs1_n_o | output | 1 | Chip select, active low |
| sram_cs2_o | output | 1 | Chip select, active high |
| sram_bc_n_o | output | 2 | Byte controls, active low, bit 0 low byte |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_dq_o | output | 16 | Data toward the memory |
| sram_dq_oe_o | output | 1 | Pad drive enable for sram_dq_o |
| sram_dq_i | input | 16 | Data from the memory pad |

## Verification
The assertions check cycle-level invariants on every clock. These are the deselected idle state, a write enable low only under a full select with the bus driven, the exact write-strobe length, address and data holding steady through an access, no bus drive while output enable is low, and the capture and zero-byte paths loading the right value. Only the bench scenarios can show end-to-end results against a memory model. These are partial byte writes merging with old contents, enabled-lane read data, requests ignored while busy, turnaround length, and the per-request busy durations seen at the handshake.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_TURN  = 2'd3
    } seq_state_e;

    // Round-up integer division for nanosecond-to-cycle conversion
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_lane_map.sv
module asram_lane_map #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] be_i,
    output logic [LANES-1:0] bc_n_o,
    output logic             any_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bc_n_o[g] = ~be_i[g];
    end

    assign any_o = |be_i;

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              zero_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_regs_t;

    cap_regs_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        if (cap_i) begin
            c_d.data  = dq_i;
            c_d.valid = 1'b1;
        end else if (zero_i) begin
            c_d.data  = '0;
            c_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rdata_o  = c_q.data;
    assign rvalid_o = c_q.valid;

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (rvalid_o && rdata_o == $past(dq_i)));

    assert_zero_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_i && !cap_i) |=> (rvalid_o && rdata_o == '0));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 16,
    parameter int LANES   = 2,
    parameter int CLK_NS  = 10,
    parameter int T_WC_NS = 70,
    parameter int T_WP_NS = 55,
    parameter int T_AW_NS = 60,
    parameter int T_DW_NS = 35,
    parameter int T_RC_NS = 70,
    parameter int T_AA_NS = 70,
    parameter int T_OE_NS = 35,
    parameter int T_HZ_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  lane_bc_n_i,
    input  logic              lane_any_i,
    output logic              ready_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs1_n_o,
    output logic              mem_cs2_o,
    output logic [LANES-1:0]  mem_bc_n_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    output logic              cap_o,
    output logic              zero_rd_o
);

    // Strobe length covers pulse width, address-to-rise and data-to-rise
    localparam int WP_CYC   = imax(imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_AW_NS, CLK_NS)),
                                   imax(cdiv(T_DW_NS, CLK_NS), 1));
    localparam int WC_CYC   = imax(cdiv(T_WC_NS, CLK_NS), WP_CYC + 1);
    localparam int RD_CYC   = imax(imax(cdiv(T_RC_NS, CLK_NS), cdiv(T_AA_NS, CLK_NS)),
                                   imax(cdiv(T_OE_NS, CLK_NS), 1));
    localparam int TURN_CYC = imax(cdiv(T_HZ_NS, CLK_NS), 1);
    localparam int MAX_CYC  = imax(imax(WC_CYC, RD_CYC), TURN_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] WP_LAST   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] WC_LAST   = CNT_W'(WC_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] WP_RUN    = CNT_W'(WP_CYC);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  bc_n;
        logic              cs1_n;
        logic              cs2;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              ready;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        st: ST_IDLE, cnt: '0, addr: '0, wdata: '0, bc_n: '1,
        cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1,
        dq_oe: 1'b0, ready: 1'b1
    };

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        cap_o     = 1'b0;
        zero_rd_o = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    if (!lane_any_i) begin
                        zero_rd_o = !we_i;
                    end else begin
                        r_d.addr  = addr_i;
                        r_d.wdata = wdata_i;
                        r_d.bc_n  = lane_bc_n_i;
                        r_d.cs1_n = 1'b0;
                        r_d.cs2   = 1'b1;
                        r_d.ready = 1'b0;
                        r_d.cnt   = '0;
                        if (we_i) begin
                            // strobe falls together with select: outputs stay high-Z
                            r_d.st    = ST_WRITE;
                            r_d.we_n  = 1'b0;
                            r_d.dq_oe = 1'b1;
                        end else begin
                            r_d.st    = ST_READ;
                            r_d.oe_n  = 1'b0;
                        end
                    end
                end
            end
            ST_WRITE: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == WP_LAST) r_d.we_n = 1'b1;
                if (r_q.cnt == WC_LAST) begin
                    r_d.st    = ST_IDLE;
                    r_d.cnt   = '0;
                    r_d.cs1_n = 1'b1;
                    r_d.cs2   = 1'b0;
                    r_d.bc_n  = '1;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.ready = 1'b1;
                end
            end
            ST_READ: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == RD_LAST) begin
                    cap_o     = 1'b1;
                    r_d.st    = ST_TURN;
                    r_d.cnt   = '0;
                    r_d.cs1_n = 1'b1;
                    r_d.cs2   = 1'b0;
                    r_d.bc_n  = '1;
                    r_d.oe_n  = 1'b1;
                end
            end
            ST_TURN: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == TURN_LAST) begin
                    r_d.st    = ST_IDLE;
                    r_d.cnt   = '0;
                    r_d.ready = 1'b1;
                end
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign ready_o     = r_q.ready;
    assign mem_addr_o  = r_q.addr;
    assign mem_cs1_n_o = r_q.cs1_n;
    assign mem_cs2_o   = r_q.cs2;
    assign mem_bc_n_o  = r_q.bc_n;
    assign mem_we_n_o  = r_q.we_n;
    assign mem_oe_n_o  = r_q.oe_n;
    assign mem_dq_o    = r_q.wdata;
    assign mem_dq_oe_o = r_q.dq_oe;

    // Checker-only run length of the write strobe
    logic [CNT_W-1:0] we_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              we_run_q <= '0;
        else if (!mem_we_n_o)    we_run_q <= we_run_q + 1'b1;
        else                     we_run_q <= '0;
    end

    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (mem_cs1_n_o && !mem_cs2_o && (&mem_bc_n_o) &&
                                 mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o && ready_o));

    assert_we_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> (!mem_cs1_n_o && mem_cs2_o && !(&mem_bc_n_o) &&
                         mem_dq_oe_o && mem_oe_n_o));

    assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (we_run_q == WP_RUN));

    assert_pins_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n_o && !$past(mem_cs1_n_o)) |->
            ($stable(mem_addr_o) && $stable(mem_dq_o) && $stable(mem_bc_n_o)));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> !mem_dq_oe_o);

    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> !ready_o);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 16,
    parameter int CLK_NS  = 10,
    parameter int T_WC_NS = 70,
    parameter int T_WP_NS = 55,
    parameter int T_AW_NS = 60,
    parameter int T_DW_NS = 35,
    parameter int T_RC_NS = 70,
    parameter int T_AA_NS = 70,
    parameter int T_OE_NS = 35,
    parameter int T_HZ_NS = 25,
    localparam int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  be_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_cs1_n_o,
    output logic              sram_cs2_o,
    output logic [LANES-1:0]  sram_bc_n_o,
    output logic              sram_we_n_o,
    output logic              sram_oe_n_o,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe_o,
    input  logic [DATA_W-1:0] sram_dq_i
);

    logic [LANES-1:0] lane_bc_n;
    logic             lane_any;
    logic             cap;
    logic             zero_rd;

    asram_lane_map #(.LANES(LANES)) u_lane_map (
        .be_i   (be_i),
        .bc_n_o (lane_bc_n),
        .any_o  (lane_any)
    );

    asram_seq #(
        .ADDR_W (ADDR_W),  .DATA_W (DATA_W),  .LANES (LANES),
        .CLK_NS (CLK_NS),  .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS),
        .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS), .T_RC_NS(T_RC_NS),
        .T_AA_NS(T_AA_NS), .T_OE_NS(T_OE_NS), .T_HZ_NS(T_HZ_NS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .we_i        (we_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .lane_bc_n_i (lane_bc_n),
        .lane_any_i  (lane_any),
        .ready_o     (ready_o),
        .mem_addr_o  (sram_addr_o),
        .mem_cs1_n_o (sram_cs1_n_o),
        .mem_cs2_o   (sram_cs2_o),
        .mem_bc_n_o  (sram_bc_n_o),
        .mem_we_n_o  (sram_we_n_o),
        .mem_oe_n_o  (sram_oe_n_o),
        .mem_dq_o    (sram_dq_o),
        .mem_dq_oe_o (sram_dq_oe_o),
        .cap_o       (cap),
        .zero_rd_o   (zero_rd)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .zero_i   (zero_rd),
        .dq_i     (sram_dq_i),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = '0;
    logic        ready;
    logic [15:0] rdata;
    logic        rvalid;
    logic [17:0] s_addr;
    logic        s_cs1_n, s_cs2, s_we_n, s_oe_n, s_dq_oe;
    logic [1:0]  s_bc_n;
    logic [15:0] s_dq_o;
    logic [15:0] s_dq_i = 16'hBEEF;

    always #2 clk = ~clk;

    asram_ctrl u_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .be_i(be), .ready_o(ready), .rdata_o(rdata),
        .rvalid_o(rvalid), .sram_addr_o(s_addr), .sram_cs1_n_o(s_cs1_n),
        .sram_cs2_o(s_cs2), .sram_bc_n_o(s_bc_n), .sram_we_n_o(s_we_n),
        .sram_oe_n_o(s_oe_n), .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe),
        .sram_dq_i(s_dq_i)
    );

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req_tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // memory model and reference image
    logic [15:0] mem     [logic [17:0]];
    logic [15:0] ref_mem [logic [17:0]];

    function automatic logic [15:0] mem_peek(input logic [17:0] a);
        if (mem.exists(a)) return mem[a];
        return 16'h0000;
    endfunction

    function automatic logic [15:0] ref_peek(input logic [17:0] a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return 16'h0000;
    endfunction

    typedef struct packed {
        logic [15:0] data;
        logic [15:0] mask;
        logic        zero;
    } sb_item_t;

    sb_item_t exp_q[$];

    // monitor state
    bit          pend = 0;
    logic [17:0] p_addr;
    logic [15:0] p_data;
    logic [1:0]  p_bc;
    int          we_run = 0, oe_run = 0, sel_run = 0, turn_cnt = 0;
    bit          turn_on = 0, had_write = 0;
    int          sel_total = 0;
    bit          prev_sel = 0, prev_we_low = 0, prev_oe_n = 1;
    logic [17:0] prev_addr;
    logic [15:0] prev_dq;
    logic [1:0]  prev_bc;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic bit sel = !s_cs1_n && s_cs2 && (s_bc_n != 2'b11);
            automatic logic [15:0] w;
            // memory model: commit a write when the overlap ends
            if (sel && !s_we_n) begin
                pend = 1; p_addr = s_addr; p_data = s_dq_o; p_bc = s_bc_n;
            end else if (pend) begin
                w = mem_peek(p_addr);
                mem[p_addr] = {p_bc[1] ? w[15:8] : p_data[15:8],
                               p_bc[0] ? w[7:0]  : p_data[7:0]};
                pend = 0;
            end
            if (sel && s_we_n && !s_oe_n) begin
                w = mem_peek(s_addr);
                s_dq_i = {s_bc_n[1] ? 8'h00 : w[15:8], s_bc_n[0] ? 8'h00 : w[7:0]};
            end else begin
                s_dq_i = 16'hBEEF;
            end

            // R3: strobe length and bus driven while writing
            if (!s_we_n) begin
                we_run++;
                had_write = 1;
                check(s_dq_oe && sel, "R3", {30'd0, s_dq_oe, sel}, 32'h3);
            end else if (we_run != 0) begin
                check(we_run == 6, "R3", we_run, 6);
                we_run = 0;
            end
            // R5: read window length
            if (!s_oe_n) oe_run++;
            else if (oe_run != 0) begin
                check(oe_run == 7, "R5", oe_run, 7);
                oe_run = 0;
            end
            // R6: no drive while memory output enabled
            if (!s_oe_n) check(!s_dq_oe, "R6", s_dq_oe, 0);
            // R4: pins steady while selected
            if (sel) begin
                sel_run++;
                sel_total++;
                if (prev_sel)
                    check(s_addr == prev_addr && s_dq_o == prev_dq && s_bc_n == prev_bc,
                          "R4", {14'd0, s_addr}, {14'd0, prev_addr});
            end else if (sel_run != 0) begin
                check(sel_run == 7, had_write ? "R3" : "R5", sel_run, 7);
                sel_run = 0;
                had_write = 0;
            end
            // R6: turnaround length
            if (!prev_oe_n && s_oe_n) begin turn_on = 1; turn_cnt = 0; end
            if (turn_on) begin
                if (ready) begin
                    check(turn_cnt == 3, "R6", turn_cnt, 3);
                    turn_on = 0;
                end else begin
                    turn_cnt++;
                    check(s_cs1_n && !s_cs2 && s_bc_n == 2'b11, "R6",
                          {29'd0, s_cs1_n, s_cs2, s_bc_n[0]}, 32'h5);
                end
            end
            // scoreboard
            if (rvalid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5", rdata, 0);
                end else begin
                    automatic sb_item_t it = exp_q.pop_front();
                    check((rdata & it.mask) == (it.data & it.mask),
                          it.zero ? "R8" : "R5", rdata & it.mask, it.data & it.mask);
                end
            end
            prev_sel  = sel;
            prev_addr = s_addr;
            prev_dq   = s_dq_o;
            prev_bc   = s_bc_n;
            prev_oe_n = s_oe_n;
        end
    end

    task automatic do_req(input bit w, input logic [17:0] a,
                          input logic [15:0] d, input logic [1:0] b);
        int n;
        int exp_busy;
        int sel_before;
        logic [15:0] old;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1; we = w; addr = a; wdata = d; be = b;
        old = ref_peek(a);
        if (!w) begin
            if (b == 2'b00) exp_q.push_back('{data: 16'h0, mask: 16'hFFFF, zero: 1'b1});
            else exp_q.push_back('{data: old, mask: {{8{b[1]}}, {8{b[0]}}}, zero: 1'b0});
        end else if (b != 2'b00) begin
            ref_mem[a] = {b[1] ? d[15:8] : old[15:8], b[0] ? d[7:0] : old[7:0]};
        end
        exp_busy   = (b == 2'b00) ? 0 : (w ? 7 : 10);
        sel_before = sel_total;
        @(negedge clk);
        req = 0;
        n = 0;
        while (!ready) begin n++; @(negedge clk); end
        check(n == exp_busy, (b == 2'b00) ? "R8" : "R7", n, exp_busy);
        if (b == 2'b00) check(sel_total == sel_before, "R8", sel_total, sel_before);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(s_cs1_n && !s_cs2 && s_bc_n == 2'b11, "R1",
              {29'd0, s_cs1_n, s_cs2, s_bc_n[0]}, 32'h5);
        check(s_we_n && s_oe_n && !s_dq_oe && ready && !rvalid, "R1",
              {27'd0, s_we_n, s_oe_n, s_dq_oe, ready, rvalid}, 32'h1A);
        rst_n = 1;
        @(negedge clk);
        check(s_cs1_n && !s_cs2 && s_bc_n == 2'b11 && s_we_n && s_oe_n && ready, "R1",
              {26'd0, s_cs1_n, s_cs2, s_bc_n, s_we_n, ready}, 32'h2F);

        // full-word write and read (R3, R5)
        do_req(1, 18'h12345, 16'hA1B2, 2'b11);
        do_req(0, 18'h12345, 16'h0, 2'b11);
        // byte lanes (R2)
        do_req(1, 18'h12345, 16'h5C6D, 2'b01);
        do_req(0, 18'h12345, 16'h0, 2'b11);
        do_req(1, 18'h12345, 16'h7EFF, 2'b10);
        do_req(0, 18'h12345, 16'h0, 2'b11);
        do_req(0, 18'h12345, 16'h0, 2'b01);
        do_req(0, 18'h12345, 16'h0, 2'b10);
        // zero-byte requests (R8)
        do_req(1, 18'h12345, 16'hFFFF, 2'b00);
        do_req(0, 18'h12345, 16'h0, 2'b11);
        do_req(0, 18'h00042, 16'h0, 2'b00);
        do_req(0, 18'h00043, 16'h0, 2'b00);

        // R7: requests held while busy are ignored
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1; we = 1; addr = 18'h3FFFF; wdata = 16'h0F0F; be = 2'b11;
        ref_mem[18'h3FFFF] = 16'h0F0F;
        @(negedge clk);
        addr = 18'h00001; wdata = 16'hDEAD;
        repeat (3) @(negedge clk);
        check(s_addr == 18'h3FFFF, "R7", {14'd0, s_addr}, 32'h3FFFF);
        req = 0;
        do_req(0, 18'h3FFFF, 16'h0, 2'b11);
        do_req(0, 18'h00001, 16'h0, 2'b11);

        // mixed pattern sweep, write then read back
        for (int i = 0; i < 8; i++)
            do_req(1, 18'(i * 18'h8421), 16'(16'h1111 * i) ^ 16'h5AA5, 2'b11);
        for (int i = 0; i < 8; i++)
            do_req(0, 18'(i * 18'h8421), 16'h0, 2'b11);
        // read followed directly by write at the same address
        do_req(0, 18'h00000, 16'h0, 2'b11);
        do_req(1, 18'h00000, 16'hC3C3, 2'b11);
        do_req(0, 18'h00000, 16'h0, 2'b11);

        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R5", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule